// File: doc/BRIEF.md
# Supervisor Interrupt Register Views

This block stores the machine-level interrupt pending word, the machine-level interrupt enable word and the interrupt delegation mask. It exposes supervisor-level pending and enable registers on the same CSR port. These supervisor registers have no storage of their own. Each one is a view of the machine word, filtered through the delegation mask. A read of the supervisor pending view also merges delegated machine-level sources into the matching supervisor bit positions.

The access port has a 12-bit CSR address, a write strobe and 64-bit write data. Read data is combinational from the address and always shows the register contents from before the current cycle's write. A write takes effect at the next rising clock edge. Privilege checks, interrupt arbitration and trap handling belong to the surrounding core.

Top module: `sup_irq_view`

## Requirements
- R1: A synchronous active-high reset clears the pending word, the enable word and the delegation mask. After reset every mapped address reads zero.
- R2: A write to 0x344 (pending), 0x304 (enable) or 0x303 (delegation) stores only the defined positions: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9 and machine external 11 (mask 0xBBB). Every other bit reads back zero.
- R3: A read of 0x144 returns three merged bits. Bit 9 is (pending[9] AND deleg[9]) OR (pending[11] AND deleg[11]). Bit 5 merges 5 with 7 the same way, and bit 1 merges 1 with 3.
- R4: A read of 0x144 returns bits 8, 4 and 0 as the pending bit ANDed with its delegation bit. All positions outside {0,1,4,5,8,9} read zero.
- R5: A read of 0x104 returns enable[i] AND deleg[i] for i in {0,1,4,5,8,9}, with no merging of machine-level bits. All other positions read zero.
- R6: A write to 0x104 loads write-data bit i into enable bit i for each i in {0,1,4,5,8,9} whose delegation bit is 1. Every other enable bit keeps its value.
- R7: A write to 0x144 sets pending[1] to wdata[1] AND deleg[1], pending[8] to pending[8] AND deleg[8], and pending[0] to pending[0] AND deleg[0]. All other pending bits keep their values.
- R8: Read data is combinational from the address and shows the register state before a write made in the same cycle. The written value becomes visible in the following cycle.
- R9: A read of any other address returns zero. A write to any other address changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| csrAddr | input | 12 | CSR address of the access |
| csrWe | input | 1 | Write strobe for the addressed register |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Combinational read data for csrAddr |

## Verification
The bench sets delegation masks that enable only the machine-level sources, or only the user-level ones. This exposes a pending view that skips the merge or merges the wrong partner bit: such a design reads zero, or the wrong bit, where the model expects a set supervisor bit. The supervisor enable and pending views are written under partial masks. A design that ignores delegation on writes, or that treats the pending-view write like the enable-view write, changes bits that the machine-level readback shows unchanged. Write-and-read in the same cycle catches read data taken after the update. Writes to unmapped neighbour addresses catch address decode that matches on too few bits.

// File: rtl/sivPkg.sv
package sivPkg;
  // interrupt bit positions
  localparam int USI = 0;
  localparam int SSI = 1;
  localparam int MSI = 3;
  localparam int UTI = 4;
  localparam int STI = 5;
  localparam int MTI = 7;
  localparam int UEI = 8;
  localparam int SEI = 9;
  localparam int MEI = 11;

  localparam int NUM_CLASS = 3;  // external, timer, software
  localparam int SUP_POS  [NUM_CLASS] = '{SEI, STI, SSI};
  localparam int MACH_POS [NUM_CLASS] = '{MEI, MTI, MSI};
  localparam int USR_POS  [NUM_CLASS] = '{UEI, UTI, USI};

  localparam logic [11:0] M_MASK12 = 12'hBBB;
  localparam logic [11:0] S_MASK12 = 12'h333;
  localparam logic [11:0] SIPW_MASK12 = 12'h103;  // bits a pending-view write may touch

  localparam logic [11:0] ADDR_SIE   = 12'h104;
  localparam logic [11:0] ADDR_SIP   = 12'h144;
  localparam logic [11:0] ADDR_DELEG = 12'h303;
  localparam logic [11:0] ADDR_MIE   = 12'h304;
  localparam logic [11:0] ADDR_MIP   = 12'h344;

  typedef enum logic [2:0] {
    RD_NONE, RD_MIP, RD_MIE, RD_DELEG, RD_SIP, RD_SIE
  } rdSel_e;

  typedef struct packed {
    logic   wrMip;
    logic   wrMie;
    logic   wrDeleg;
    logic   wrSip;
    logic   wrSie;
    rdSel_e rdSel;
  } csrStrobe_t;
endpackage

// File: rtl/sivCtrl.sv
module sivCtrl
  import sivPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  output csrStrobe_t        stb
);
  always_comb begin
    stb = '0;
    if (csrAddr == ADDR_W'(ADDR_MIP)) begin
      stb.rdSel = RD_MIP;
      stb.wrMip = csrWe;
    end else if (csrAddr == ADDR_W'(ADDR_MIE)) begin
      stb.rdSel = RD_MIE;
      stb.wrMie = csrWe;
    end else if (csrAddr == ADDR_W'(ADDR_DELEG)) begin
      stb.rdSel   = RD_DELEG;
      stb.wrDeleg = csrWe;
    end else if (csrAddr == ADDR_W'(ADDR_SIP)) begin
      stb.rdSel = RD_SIP;
      stb.wrSip = csrWe;
    end else if (csrAddr == ADDR_W'(ADDR_SIE)) begin
      stb.rdSel = RD_SIE;
      stb.wrSie = csrWe;
    end
  end
endmodule

// File: rtl/sivData.sv
module sivData
  import sivPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  csrStrobe_t      stb,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  localparam logic [XLEN-1:0] M_MASK = XLEN'(M_MASK12);
  localparam logic [XLEN-1:0] S_MASK = XLEN'(S_MASK12);

  logic [XLEN-1:0] mipQ, mieQ, delegQ;
  logic [XLEN-1:0] mipNext, mieNext, delegNext;
  logic [XLEN-1:0] sipView, sieView;
  logic [XLEN-1:0] sieWrMask;

  // supervisor pending view: merge delegated machine sources
  always_comb begin
    sipView = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      sipView[SUP_POS[k]] = (mipQ[SUP_POS[k]] & delegQ[SUP_POS[k]]) |
                            (mipQ[MACH_POS[k]] & delegQ[MACH_POS[k]]);
      sipView[USR_POS[k]] = mipQ[USR_POS[k]] & delegQ[USR_POS[k]];
    end
  end

  assign sieView   = mieQ & delegQ & S_MASK;
  assign sieWrMask = delegQ & S_MASK;

  always_comb begin
    mipNext = mipQ;
    if (stb.wrMip) begin
      mipNext = wdata & M_MASK;
    end else if (stb.wrSip) begin
      mipNext[SSI] = wdata[SSI] & delegQ[SSI];
      mipNext[UEI] = mipQ[UEI] & delegQ[UEI];
      mipNext[USI] = mipQ[USI] & delegQ[USI];
    end
  end

  always_comb begin
    mieNext = mieQ;
    if (stb.wrMie)      mieNext = wdata & M_MASK;
    else if (stb.wrSie) mieNext = (mieQ & ~sieWrMask) | (wdata & sieWrMask);
  end

  assign delegNext = stb.wrDeleg ? (wdata & M_MASK) : delegQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      mipQ   <= '0;
      mieQ   <= '0;
      delegQ <= '0;
    end else begin
      mipQ   <= mipNext;
      mieQ   <= mieNext;
      delegQ <= delegNext;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_MIP:   rdata = mipQ;
      RD_MIE:   rdata = mieQ;
      RD_DELEG: rdata = delegQ;
      RD_SIP:   rdata = sipView;
      RD_SIE:   rdata = sieView;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sup_irq_view.sv
module sup_irq_view
  import sivPkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata
);
  csrStrobe_t stb;

  sivCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .stb     (stb)
  );

  sivData #(.XLEN(XLEN)) uData (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .wdata (csrWdata),
    .rdata (csrRdata)
  );
endmodule

// File: rtl/sivData_chk.sv
module sivData_chk
  import sivPkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input csrStrobe_t      stb,
  input logic [XLEN-1:0] rdata,
  input logic [XLEN-1:0] mipQ,
  input logic [XLEN-1:0] mieQ,
  input logic [XLEN-1:0] delegQ
);
  localparam logic [XLEN-1:0] M_MASK    = XLEN'(M_MASK12);
  localparam logic [XLEN-1:0] S_MASK    = XLEN'(S_MASK12);
  localparam logic [XLEN-1:0] SIPW_MASK = XLEN'(SIPW_MASK12);

  logic anyWr;
  assign anyWr = stb.wrMip | stb.wrMie | stb.wrDeleg | stb.wrSip | stb.wrSie;

  // R2: stored words never hold undefined positions
  p_defined_bits_r2: assert property (@(posedge clk) disable iff (rst)
    ((mipQ | mieQ | delegQ) & ~M_MASK) == '0);

  // R4: supervisor pending view stays inside its layout
  p_sip_layout_r4: assert property (@(posedge clk) disable iff (rst)
    (stb.rdSel == RD_SIP) |-> ((rdata & ~S_MASK) == '0));

  // R5: supervisor enable view never shows a bit the enable word lacks
  p_sie_subset_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.rdSel == RD_SIE) |-> ((rdata & ~mieQ) == '0));

  // R6: enable-view write leaves undelegated bits alone
  p_sie_nondeleg_kept_r6: assert property (@(posedge clk) disable iff (rst)
    stb.wrSie |=> (((mieQ ^ $past(mieQ)) & ~$past(delegQ)) == '0));

  // R7: pending-view write touches only bits 0, 1 and 8
  p_sip_write_scope_r7: assert property (@(posedge clk) disable iff (rst)
    stb.wrSip |=> (((mipQ ^ $past(mipQ)) & ~SIPW_MASK) == '0));

  // R9: unmapped reads return zero
  p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (stb.rdSel == RD_NONE) |-> (rdata == '0));

  // R9: no write strobe leaves all state unchanged
  p_no_write_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !anyWr |=> ($stable(mipQ) && $stable(mieQ) && $stable(delegQ)));
endmodule

bind sivData sivData_chk #(.XLEN(XLEN)) uChk (
  .clk    (clk),
  .rst    (rst),
  .stb    (stb),
  .rdata  (rdata),
  .mipQ   (mipQ),
  .mieQ   (mieQ),
  .delegQ (delegQ)
);

// File: tb/sim_sup_irq_view.sv
module sim_sup_irq_view;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csrAddr = '0;
  logic        csrWe = 1'b0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [63:0] refPend = '0, refEn = '0, refDel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_irq_view u0 (
    .clk(clk), .rst(rst), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(csrRdata)
  );

  function automatic logic [63:0] refRead(input logic [11:0] a);
    logic [63:0] r = '0;
    case (a)
      12'h344: r = refPend;
      12'h304: r = refEn;
      12'h303: r = refDel;
      12'h144: begin
        r[9] = (refPend[9] && refDel[9]) || (refPend[11] && refDel[11]);
        r[5] = (refPend[5] && refDel[5]) || (refPend[7] && refDel[7]);
        r[1] = (refPend[1] && refDel[1]) || (refPend[3] && refDel[3]);
        r[8] = refPend[8] && refDel[8];
        r[4] = refPend[4] && refDel[4];
        r[0] = refPend[0] && refDel[0];
      end
      12'h104: begin
        foreach (r[i]) if (i == 0 || i == 1 || i == 4 || i == 5 || i == 8 || i == 9)
          r[i] = refEn[i] && refDel[i];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic refWrite(input logic [11:0] a, input logic [63:0] d);
    case (a)
      12'h344: refPend = d & 64'hBBB;
      12'h304: refEn   = d & 64'hBBB;
      12'h303: refDel  = d & 64'hBBB;
      12'h104: begin
        for (int i = 0; i < 12; i++)
          if ((i == 0 || i == 1 || i == 4 || i == 5 || i == 8 || i == 9) && refDel[i])
            refEn[i] = d[i];
      end
      12'h144: begin
        logic oldUei = refPend[8];
        logic oldUsi = refPend[0];
        refPend[1] = d[1] & refDel[1];
        refPend[8] = oldUei & refDel[8];
        refPend[0] = oldUsi & refDel[0];
      end
      default: ;
    endcase
  endtask

  // one access per cycle: drive at falling edge, compare before rising edge
  task automatic access(input logic [11:0] a, input logic we, input logic [63:0] d,
                        input string tag);
    logic [63:0] exp;
    @(negedge clk);
    csrAddr = a; csrWe = we; csrWdata = d;
    #1;
    exp = refRead(a);
    checks++;
    if (csrRdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h we=%0b actual=%h expected=%h", tag, a, we, csrRdata, exp);
    end
    @(posedge clk);
    if (we) refWrite(a, d);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    access(a, 1'b0, 64'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input string tag);
    access(a, 1'b1, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset: dirty the state first, then reset
    rst = 1'b0;
    @(negedge clk); csrAddr = 12'h344; csrWe = 1'b1; csrWdata = '1;
    @(negedge clk); rst = 1'b1; csrWe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    refPend = '0; refEn = '0; refDel = '0;
    // R1
    rd(12'h344, "R1"); rd(12'h304, "R1"); rd(12'h303, "R1");
    rd(12'h144, "R1"); rd(12'h104, "R1");

    // R2: only defined positions stored
    wr(12'h344, '1, "R2"); wr(12'h304, '1, "R2"); wr(12'h303, '1, "R2");
    rd(12'h344, "R2"); rd(12'h304, "R2"); rd(12'h303, "R2");

    // R3: merge through machine-only delegation
    wr(12'h303, 64'h888, "R3");
    rd(12'h144, "R3");
    wr(12'h303, 64'h0, "R3");
    rd(12'h144, "R3");
    wr(12'h303, 64'h222, "R3");
    wr(12'h344, 64'h222, "R3");
    rd(12'h144, "R3");
    wr(12'h344, '1, "R3");

    // R4: user-level bits masked
    wr(12'h303, 64'h111, "R4");
    rd(12'h144, "R4");
    wr(12'h303, 64'h100, "R4");
    rd(12'h144, "R4");

    // R5: enable view, no merge
    wr(12'h303, 64'h888, "R5");
    rd(12'h104, "R5");
    wr(12'h303, 64'h333, "R5");
    rd(12'h104, "R5");

    // R6: enable-view write under partial delegation
    wr(12'h304, 64'h0, "R6");
    wr(12'h303, 64'h022, "R6");
    wr(12'h104, '1, "R6");
    rd(12'h304, "R6");
    wr(12'h303, 64'h200, "R6");
    wr(12'h104, 64'h0, "R6");
    rd(12'h304, "R6");
    wr(12'h303, 64'hBBB, "R6");
    wr(12'h104, 64'h0, "R6");
    rd(12'h304, "R6");

    // R7: pending-view write
    wr(12'h344, '1, "R7");
    wr(12'h303, 64'h002, "R7");
    wr(12'h144, 64'h0, "R7");
    rd(12'h344, "R7");
    wr(12'h344, '1, "R7");
    wr(12'h303, 64'h103, "R7");
    wr(12'h144, 64'h0, "R7");
    rd(12'h344, "R7");
    wr(12'h144, '1, "R7");
    rd(12'h344, "R7");

    // R8: same-cycle write returns old value, new value next cycle
    wr(12'h304, 64'h0, "R8");
    wr(12'h304, 64'hBBB, "R8");
    rd(12'h304, "R8");

    // R9: unmapped addresses
    wr(12'h305, '1, "R9"); wr(12'h343, 64'h0, "R9"); wr(12'h145, '1, "R9");
    rd(12'h344, "R9"); rd(12'h304, "R9"); rd(12'h303, "R9");
    rd(12'h000, "R9"); rd(12'hFFF, "R9"); rd(12'h105, "R9");

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      case ($urandom % 8)
        0: a = 12'h104; 1: a = 12'h144; 2: a = 12'h303; 3: a = 12'h304;
        4: a = 12'h344; 5: a = 12'h104; 6: a = 12'h144; default: a = 12'h306;
      endcase
      access(a, 1'($urandom % 2), {$urandom, $urandom}, "R8 mixed");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule